// File: doc/BRIEF.md
# Disk PIO Read Command Sequencer

This block sits behind the command register of a disk task file. It turns a command byte into status, error and interrupt activity. For the read commands it also steps a host through a programmed-I/O transfer of 16-bit data-port reads. It keeps a byte index into the transfer, the transfer length and the current logical block address.

When the index crosses into a new sector, it asks a storage-side agent for that sector and waits for the agent's acknowledge. It decides, read by read, whether data request stays raised and whether an interrupt fires.

Interrupts are paced by the active command:
- A single-sector read interrupts after every sector.
- A read-multiple interrupts after every block, whose size is set by the last set-multiple command.
- The last word of a transfer always interrupts.

The sector buffer itself lives on the storage side and is addressed word by word.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset, status reads 0x50, the error code reads 0x00, and irq, rd_valid and fetch_req are low. Status bits: 7 busy, 6 ready, 5 write fault, 4 seek complete, 3 data request, 0 error.
- R2: Identify (0xEC) with is_disk high does the following:
  - sets the error code to 0x00 and status to 0x58, and pulses irq;
  - then serves one sector of words from the storage buffer without any fetch;
  - after the last word, drops data request (status 0x50) without an interrupt.
- R3: An abort sets status to 0x41 and the error code to 0x04, pulses irq and ends any transfer. Identify with is_disk low aborts.
- R4: Set features (0xEF) clears busy, write fault and error, sets ready and seek complete, and pulses irq. Commands 0x91 and 0x10 clear error, set ready and seek complete, and pulse irq.
- R5: Set multiple (0xC6) aborts when sect_num exceeds MAX_MULT. Otherwise it does the following:
  - stores sect_cnt as the block size, with 0 stored as 1;
  - sets ready, clears error, and pulses irq.
- R6: Read commands 0x20, 0x21 and 0xC4 each start a transfer:
  - The LBA is loaded from start_lba, and the length is sect_cnt×SECTOR_BYTES, with a count of 0 meaning 256 sectors.
  - Status becomes 0x90, the error code becomes 0x00, and fetch_req rises with fetch_lba equal to start_lba.
  - fetch_req and fetch_lba hold until fetch_ack.
  - At the acknowledge, busy clears and status becomes 0x58.
- R7: A data-port read at a nonzero sector boundary does the following before returning its word:
  - increments the LBA and sets busy;
  - requests the sector at the new LBA.
- R8: Each read returns the buffer word at word_addr, which is the index divided by 2, with the lower-addressed byte in bits 7:0. rd_data is returned with a one-cycle rd_valid, either one cycle after the read or at the fetch acknowledge. The index then advances by 2.
- R9: Commands 0x20 and 0x21 pulse irq together with the word that completes each sector.
- R10: Command 0xC4 pulses irq together with the word that completes each block of the stored size. It also pulses irq on the final word of the transfer, whether or not a block is complete.
- R11: Status stays 0x58 after every read while bytes remain, and becomes 0x50 after the final word. No interrupt is ever raised while busy is set.
- R12: A data-port read with no transfer active is an overrun. It returns rd_data 0x0000 with rd_valid, sets the status error bit (0x51 after a finished read) and raises no irq.
- R13: Any other command byte is ignored: status and the error code are unchanged and no irq is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_code | input | 8 | Command byte |
| sect_cnt | input | 8 | Sector count register value |
| sect_num | input | 8 | Sector number register value |
| start_lba | input | LBA_W | Starting block address for reads |
| is_disk | input | 1 | Selected drive is a disk |
| data_rd | input | 1 | 16-bit data-port read strobe |
| rd_data | output | 16 | Returned data word |
| rd_valid | output | 1 | rd_data valid pulse |
| status | output | 8 | Status register |
| error_code | output | 8 | Error register |
| irq | output | 1 | Interrupt pulse |
| fetch_req | output | 1 | Sector fetch request, held until acknowledged |
| fetch_lba | output | LBA_W | Block address to fetch |
| fetch_ack | input | 1 | Fetch complete, buffer holds the sector |
| word_addr | output | SB_W-1 | Word offset into the sector buffer |
| word_data | input | 16 | Buffer word at word_addr |

## Verification
Command effects are registered once, so status, error code and irq are sampled on the falling edge right after the strobe cycle. A read that needs no fetch returns its word, status and irq on the falling edge one cycle after the strobe. A read at a sector boundary returns them only at the cycle after the acknowledge, which the storage model gives after a fixed delay. The bench therefore waits for rd_valid and then compares data, irq and status on that same falling edge. The bench uses a 32-byte sector, so full sweeps are short, including a 256-sector transfer for a count of 0. Expected words, interrupt positions and LBAs are computed arithmetically from the word number.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
    typedef enum logic [2:0] {
        OP_NONE, OP_IDENT, OP_FEAT, OP_PARAM, OP_SETMULT, OP_RD_ONE, OP_RD_MULT
    } op_e;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER} st_e;

    localparam int BSY  = 7;
    localparam int DRDY = 6;
    localparam int DF   = 5;
    localparam int DSC  = 4;
    localparam int DRQ  = 3;
    localparam int ERR  = 0;

    localparam logic [7:0] STAT_RESET = 8'h50;
    localparam logic [7:0] STAT_ABORT = 8'h41;
    localparam logic [7:0] STAT_IDENT = 8'h58;
    localparam logic [7:0] STAT_START = 8'h90;
    localparam logic [7:0] ERR_ABORT  = 8'h04;
endpackage

// File: rtl/ata_cmd_class.sv
module ata_cmd_class
    import ata_seq_pkg::*;
(
    input  logic [7:0] cmd,
    output op_e        op
);
    always_comb begin
        case (cmd)
            8'hEC:        op = OP_IDENT;
            8'hEF:        op = OP_FEAT;
            8'h91, 8'h10: op = OP_PARAM;
            8'hC6:        op = OP_SETMULT;
            8'h20, 8'h21: op = OP_RD_ONE;
            8'hC4:        op = OP_RD_MULT;
            default:      op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/ata_pace.sv
module ata_pace #(
    parameter int SB_W  = 9,
    parameter int IDX_W = 18
) (
    input  logic [IDX_W-1:0] idx_next,
    input  logic [IDX_W-1:0] len,
    input  logic [8:0]       sib,
    input  logic [8:0]       blk,
    output logic             sector_end,
    output logic             block_end,
    output logic             last
);
    always_comb begin
        sector_end = (idx_next[SB_W-1:0] == '0);
        block_end  = sector_end && ((sib + 9'd1) == blk);
        last       = (idx_next == len);
    end
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_seq_pkg::*;
#(
    parameter int LBA_W        = 28,
    parameter int SECTOR_BYTES = 512,
    parameter int MAX_MULT     = 16,
    localparam int SB_W        = $clog2(SECTOR_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_code,
    input  logic [7:0]       sect_cnt,
    input  logic [7:0]       sect_num,
    input  logic [LBA_W-1:0] start_lba,
    input  logic             is_disk,
    input  logic             data_rd,
    output logic [15:0]      rd_data,
    output logic             rd_valid,
    output logic [7:0]       status,
    output logic [7:0]       error_code,
    output logic             irq,
    output logic             fetch_req,
    output logic [LBA_W-1:0] fetch_lba,
    input  logic             fetch_ack,
    output logic [SB_W-2:0]  word_addr,
    input  logic [15:0]      word_data
);
    localparam int IDX_W = SB_W + 9;

    typedef struct packed {
        st_e              st;
        logic             id_mode;
        logic             pend;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] len;
        logic [LBA_W-1:0] lba;
        logic [8:0]       blk;
        logic [8:0]       sib;
        logic [8:0]       mult;
        logic [7:0]       stat;
        logic [7:0]       err;
        logic             irq;
        logic             rv;
        logic [15:0]      rdat;
    } seq_t;

    seq_t q, d;
    op_e  op;
    logic [IDX_W-1:0] adv;
    logic sector_end, block_end, last;
    logic deliver, abort;
    logic [8:0] nsec;

    ata_cmd_class u_class (.cmd(cmd_code), .op(op));

    assign adv = q.idx + IDX_W'(2);

    ata_pace #(.SB_W(SB_W), .IDX_W(IDX_W)) u_pace (
        .idx_next(adv), .len(q.len), .sib(q.sib), .blk(q.blk),
        .sector_end(sector_end), .block_end(block_end), .last(last)
    );

    always_comb begin
        d       = q;
        d.irq   = 1'b0;
        d.rv    = 1'b0;
        deliver = 1'b0;
        abort   = 1'b0;
        nsec    = (sect_cnt == 8'd0) ? 9'd256 : {1'b0, sect_cnt};

        case (q.st)
            ST_FETCH: if (fetch_ack) begin
                d.stat[BSY]  = 1'b0;
                d.stat[DRDY] = 1'b1;
                d.pend       = 1'b0;
                d.st         = ST_XFER;
                if (q.pend) deliver = 1'b1;
                else        d.stat[DRQ] = 1'b1;
            end
            ST_XFER: if (data_rd) begin
                if (!q.id_mode && q.idx[SB_W-1:0] == '0 && q.idx != '0) begin
                    d.st        = ST_FETCH;
                    d.lba       = q.lba + LBA_W'(1);
                    d.pend      = 1'b1;
                    d.stat[BSY] = 1'b1;
                end else begin
                    deliver = 1'b1;
                end
            end
            default: if (data_rd) begin
                d.rv        = 1'b1;
                d.rdat      = 16'h0000;
                d.stat[ERR] = 1'b1;
            end
        endcase

        if (deliver) begin
            d.rv   = 1'b1;
            d.rdat = word_data;
            d.idx  = adv;
            if (q.id_mode) begin
                if (last) begin
                    d.stat[DRQ] = 1'b0;
                    d.st        = ST_IDLE;
                end
            end else begin
                if (sector_end) d.sib = block_end ? 9'd0 : q.sib + 9'd1;
                if (block_end || last) begin
                    d.irq        = 1'b1;
                    d.stat[BSY]  = 1'b0;
                    d.stat[DRDY] = 1'b1;
                    d.stat[DRQ]  = !last;
                    if (last) d.st = ST_IDLE;
                end
            end
        end

        if (cmd_we) begin
            case (op)
                OP_IDENT: begin
                    if (is_disk) begin
                        d.err     = 8'h00;
                        d.stat    = STAT_IDENT;
                        d.irq     = 1'b1;
                        d.id_mode = 1'b1;
                        d.idx     = '0;
                        d.len     = IDX_W'(SECTOR_BYTES);
                        d.pend    = 1'b0;
                        d.st      = ST_XFER;
                    end else begin
                        abort = 1'b1;
                    end
                end
                OP_FEAT: begin
                    d.stat[BSY]  = 1'b0;
                    d.stat[DF]   = 1'b0;
                    d.stat[ERR]  = 1'b0;
                    d.stat[DRDY] = 1'b1;
                    d.stat[DSC]  = 1'b1;
                    d.irq        = 1'b1;
                end
                OP_PARAM: begin
                    d.stat[ERR]  = 1'b0;
                    d.stat[DRDY] = 1'b1;
                    d.stat[DSC]  = 1'b1;
                    d.irq        = 1'b1;
                end
                OP_SETMULT: begin
                    if (int'(sect_num) > MAX_MULT) begin
                        abort = 1'b1;
                    end else begin
                        d.mult       = (sect_cnt == 8'd0) ? 9'd1 : {1'b0, sect_cnt};
                        d.stat[DRDY] = 1'b1;
                        d.stat[ERR]  = 1'b0;
                        d.irq        = 1'b1;
                    end
                end
                OP_RD_ONE, OP_RD_MULT: begin
                    d.blk     = (op == OP_RD_ONE) ? 9'd1 : q.mult;
                    d.lba     = start_lba;
                    d.len     = {nsec, {SB_W{1'b0}}};
                    d.idx     = '0;
                    d.sib     = 9'd0;
                    d.id_mode = 1'b0;
                    d.pend    = 1'b0;
                    d.st      = ST_FETCH;
                    d.stat    = STAT_START;
                    d.err     = 8'h00;
                end
                default: ;
            endcase
            if (abort) begin
                d.stat = STAT_ABORT;
                d.err  = ERR_ABORT;
                d.irq  = 1'b1;
                d.st   = ST_IDLE;
                d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.id_mode <= 1'b0;
            q.pend    <= 1'b0;
            q.idx     <= '0;
            q.len     <= '0;
            q.lba     <= '0;
            q.blk     <= 9'd1;
            q.sib     <= 9'd0;
            q.mult    <= 9'd1;
            q.stat    <= STAT_RESET;
            q.err     <= 8'h00;
            q.irq     <= 1'b0;
            q.rv      <= 1'b0;
            q.rdat    <= 16'h0000;
        end else begin
            q <= d;
        end
    end

    assign rd_data    = q.rdat;
    assign rd_valid   = q.rv;
    assign status     = q.stat;
    assign error_code = q.err;
    assign irq        = q.irq;
    assign fetch_req  = (q.st == ST_FETCH);
    assign fetch_lba  = q.lba;
    assign word_addr  = q.idx[SB_W-1:1];
endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk #(
    parameter int LBA_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic             data_rd,
    input logic             fetch_req,
    input logic             fetch_ack,
    input logic [LBA_W-1:0] fetch_lba,
    input logic             rd_valid,
    input logic             irq,
    input logic [7:0]       status
);
    // R6
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_ack && !cmd_we |=> fetch_req && $stable(fetch_lba));

    // R7
    fetch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> status[7]);

    // R8
    valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(data_rd || fetch_ack));

    // R11
    irq_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !status[7]);
endmodule

bind ata_pio_seq ata_pio_seq_chk #(.LBA_W(LBA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .data_rd(data_rd),
    .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_lba(fetch_lba),
    .rd_valid(rd_valid), .irq(irq), .status(status)
);

// File: tb/sim_ata_pio_seq.sv
module sim_ata_pio_seq;
    localparam int LW  = 28;
    localparam int SB  = 32;
    localparam int WPS = SB / 2;
    localparam int MM  = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_we = 1'b0, is_disk = 1'b1, data_rd = 1'b0, fetch_ack = 1'b0;
    logic [7:0] cmd_code = 8'h00, sect_cnt = 8'h00, sect_num = 8'h00;
    logic [LW-1:0] start_lba = '0, model_lba = '0;
    logic [15:0] rd_data, word_data;
    logic rd_valid, irq, fetch_req;
    logic [7:0] status, error_code;
    logic [LW-1:0] fetch_lba;
    logic [$clog2(SB)-2:0] word_addr;
    int tests = 0, fails = 0, n_fetch = 0;

    always #10 clk = ~clk;

    function automatic logic [15:0] mk(input logic [LW-1:0] l, input int a);
        return {l[7:0] + 8'h11, 8'(a) ^ 8'hA5};
    endfunction

    assign word_data = mk(model_lba, int'(word_addr));

    ata_pio_seq #(.LBA_W(LW), .SECTOR_BYTES(SB), .MAX_MULT(MM)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .sect_cnt(sect_cnt), .sect_num(sect_num), .start_lba(start_lba),
        .is_disk(is_disk), .data_rd(data_rd), .rd_data(rd_data), .rd_valid(rd_valid),
        .status(status), .error_code(error_code), .irq(irq), .fetch_req(fetch_req),
        .fetch_lba(fetch_lba), .fetch_ack(fetch_ack), .word_addr(word_addr),
        .word_data(word_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // storage model: acknowledges a fetch after a fixed delay
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (fetch_ack) fetch_ack = 1'b0;
            else if (fetch_req) begin
                if (dly == 2) begin
                    model_lba = fetch_lba;
                    fetch_ack = 1'b1;
                    n_fetch++;
                    dly = 0;
                end else dly++;
            end
        end
    end

    task automatic issue(input logic [7:0] c, input logic [7:0] cnt, input logic [7:0] num);
        cmd_code = c; sect_cnt = cnt; sect_num = num; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic host_read(output logic [15:0] dv, output logic [7:0] sv, output logic iv);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (rd_valid) break;
            @(negedge clk);
        end
        dv = rd_valid ? rd_data : 16'hDEAD;
        sv = status;
        iv = irq;
    endtask

    task automatic xfer(input logic [7:0] c, input int cnt, input int start, input int blk,
                        input string ptag);
        int nsec, words, de, ie, se, ni, f0;
        logic [15:0] dv; logic [7:0] sv; logic iv;
        start_lba = LW'(start);
        f0 = n_fetch;
        issue(c, 8'(cnt), 8'h00);
        chk("R6 status at read start", status, 8'h90);
        chk("R6 fetch_req at read start", fetch_req, 1);
        for (int k = 0; k < 20; k++) begin
            if (status[3]) break;
            @(negedge clk);
        end
        chk("R6 status after first fetch", status, 8'h58);
        chk("R6 first fetch lba", int'(model_lba), start);
        nsec = (cnt == 0) ? 256 : cnt;
        words = nsec * WPS;
        de = 0; ie = 0; se = 0; ni = 0;
        for (int w = 0; w < words; w++) begin
            bit ei;
            host_read(dv, sv, iv);
            if (dv != mk(LW'(start + w / WPS), w % WPS)) de++;
            ei = ((w + 1) % (WPS * blk) == 0) || (w + 1 == words);
            if (iv != ei) ie++;
            if (iv) ni++;
            if (sv != ((w + 1 == words) ? 8'h50 : 8'h58)) se++;
        end
        chk("R8 data word mismatches", de, 0);
        chk({ptag, " irq position mismatches"}, ie, 0);
        chk({ptag, " irq count"}, ni, (nsec + blk - 1) / blk);
        chk("R11 status mismatches", se, 0);
        chk("R7 fetch count", n_fetch - f0, nsec);
        chk("R7 last fetched lba", int'(model_lba), start + nsec - 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] dv; logic [7:0] sv; logic iv;
        int de, ni, f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", status, 8'h50);
        chk("R1 error", error_code, 0);
        chk("R1 irq/valid/fetch", {irq, rd_valid, fetch_req}, 0);

        issue(8'h30, 8'h01, 8'h00);
        chk("R13 status unchanged", status, 8'h50);
        chk("R13 no irq", irq, 0);
        chk("R13 error unchanged", error_code, 0);

        is_disk = 1'b0;
        issue(8'hEC, 8'h01, 8'h00);
        chk("R3 abort status", status, 8'h41);
        chk("R3 abort error", error_code, 8'h04);
        chk("R3 abort irq", irq, 1);
        issue(8'hEF, 8'h00, 8'h00);
        chk("R4 set features status", status, 8'h50);
        chk("R4 set features irq", irq, 1);
        issue(8'hEC, 8'h01, 8'h00);
        issue(8'h91, 8'h00, 8'h00);
        chk("R4 0x91 status", status, 8'h50);
        chk("R4 0x91 irq", irq, 1);
        issue(8'hEC, 8'h01, 8'h00);
        issue(8'h10, 8'h00, 8'h00);
        chk("R4 0x10 status", status, 8'h50);
        is_disk = 1'b1;

        issue(8'hEC, 8'h01, 8'h00);
        chk("R2 identify status", status, 8'h58);
        chk("R2 identify error", error_code, 0);
        chk("R2 identify irq", irq, 1);
        f0 = n_fetch; de = 0; ni = 0;
        for (int w = 0; w < WPS; w++) begin
            host_read(dv, sv, iv);
            if (dv != mk(model_lba, w)) de++;
            if (iv) ni++;
        end
        chk("R2 identify data mismatches", de, 0);
        chk("R2 identify no irq on reads", ni, 0);
        chk("R2 identify final status", status, 8'h50);
        chk("R2 identify no fetch", n_fetch - f0, 0);

        issue(8'hC6, 8'h02, 8'(MM + 1));
        chk("R5 set multiple over max aborts", status, 8'h41);
        chk("R5 set multiple over max error", error_code, 8'h04);
        issue(8'hC6, 8'h02, 8'(MM));
        chk("R5 set multiple status", status, 8'h40);
        chk("R5 set multiple irq", irq, 1);

        xfer(8'h20, 3, 100, 1, "R9");
        host_read(dv, sv, iv);
        chk("R12 overrun data", dv, 0);
        chk("R12 overrun status", sv, 8'h51);
        chk("R12 overrun no irq", iv, 0);

        xfer(8'h21, 2, 7, 1, "R9");
        xfer(8'hC4, 5, 2000, 2, "R10");
        issue(8'hC6, 8'h00, 8'h00);
        xfer(8'hC4, 3, 300, 1, "R5");
        issue(8'hC6, 8'd16, 8'h00);
        xfer(8'hC4, 0, 5000, 16, "R10");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule